// File: doc/BRIEF.md
# I2C Master Receive Count Controller

This block decides, byte by byte, when an I2C master read ends. Software programs a byte target and a continuous-read flag into a small count register. The bit engine reports each received byte. The controller then answers with an acknowledge decision: ACK to keep reading, or NACK for the final byte, followed by a STOP request. An 8-bit current-count value shows how many bytes the running read has delivered so far. The count wraps from 255 to 0. Software can therefore end a continuous read by clearing the flag and writing a target one above the current count. If the new target is below the current count, reception runs on through the wrap until the count equals the target.

The same sequencer handles the write direction. While the transmit request is held, the engine is told to keep sending. If software withdraws the request, the transfer ends once the byte on the wire is finished. When a STOP completes, a sticky transaction-complete flag is set, and it stays set until a clear strobe arrives. Dropping the master enable returns the sequencer to idle at once.

The states are IDLE, RX, RX_ACK, RX_NACK, STOP, TX and TX_LAST. The transitions are:
- IDLE to RX on a START with read direction, or to TX on a START with write direction.
- RX to RX_ACK or RX_NACK on a received byte.
- RX_ACK back to RX.
- RX_NACK to STOP.
- STOP to IDLE on stop completion.
- TX stays in TX on a sent byte while the request is held. It goes to STOP on a sent byte without the request, and to TX_LAST when the request drops between bytes.
- TX_LAST to STOP on the sent byte.
- Any state to IDLE when the master enable is low.

Top module: `mrx_count_ctrl`

## Requirements
- R1: The count register resets to 0. A write strobe loads it with the 9-bit write data: bits 7:0 are the byte target and bit 8 is the continuous-read flag. Both fields are readable the cycle after the write.
- R2: A START seen in IDLE clears the current count to 0. Each byte received in RX raises it by one, modulo 256.
- R3: One cycle after a byte is received in RX, `ack_go` pulses for one cycle. `ack_nack` is 0 on that pulse unless the byte is the last one.
- R4: A byte is the last one when the flag is clear and the incremented count equals the target. In that case `ack_go` comes with `ack_nack`=1, and on the next cycle `stop_req` rises. `stop_req` stays high until `stop_done`.
- R5: While the continuous-read flag is set, no byte ever gets NACK, whatever the count.
- R6: The decision for a byte uses the register value held before that byte's cycle. A write in the same cycle as a received byte first counts for the following byte. Clearing the flag and writing count+1 ends the read on the next byte.
- R7: A target below the current count makes reception continue through the 255-to-0 wrap until the count equals the target.
- R8: `tx_more` is high only in TX. If the request is low on a sent byte, or was withdrawn between bytes (it may be raised again later), STOP follows that byte.
- R9: `txn_done` is set on the cycle after `stop_done` during STOP. It holds until `done_clr`. If set and clear happen in the same cycle, the set wins.
- R10: With `mst_en` low, the next cycle shows no `ack_go`, `stop_req` or `tx_more`, and a current count of 0. START and byte inputs have no effect while disabled.
- R11: A target of 0 with the flag clear ends the read after 256 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mst_en | input | 1 | Master enable; low forces IDLE |
| cfg_wr | input | 1 | Write strobe for the count register |
| cfg_wdata | input | 9 | {continuous flag, byte target} |
| cfg_target | output | 8 | Programmed byte target |
| cfg_cont | output | 1 | Programmed continuous-read flag |
| cur_count | output | 8 | Bytes received in the current read |
| start | input | 1 | START issued by the bit engine |
| start_rd | input | 1 | Direction of that START: 1 read, 0 write |
| rx_byte | input | 1 | One received byte completed |
| ack_go | output | 1 | Acknowledge decision valid (one cycle) |
| ack_nack | output | 1 | 1 = NACK this byte, 0 = ACK |
| tx_req | input | 1 | Transmit request from software |
| tx_byte | input | 1 | One transmitted byte completed |
| tx_more | output | 1 | Engine may continue sending |
| stop_req | output | 1 | Generate STOP; held until done |
| stop_done | input | 1 | STOP completed on the bus |
| done_clr | input | 1 | Write-one-to-clear for the done flag |
| txn_done | output | 1 | Sticky transaction-complete flag |

## Verification
A wrong state would show up at the ports one cycle after the byte that should have triggered it. A missed transition leaves `ack_go` absent, a wrong termination test flips `ack_nack`, and a stuck STOP state keeps `stop_req` high past `stop_done`. A wrong count path shows up in `cur_count` on the cycle after the byte. A wrap or reprogramming fault may stay hidden until the byte where termination should occur, which can be up to 256 bytes later, so the long wrap runs are compared on every cycle rather than only at their end.

// File: rtl/mrxc_pkg.sv
package mrxc_pkg;

    typedef enum logic [2:0] {
        S_IDLE    = 3'd0,
        S_RX      = 3'd1,
        S_RX_ACK  = 3'd2,
        S_RX_NACK = 3'd3,
        S_STOP    = 3'd4,
        S_TX      = 3'd5,
        S_TX_LAST = 3'd6
    } mrxc_state_e;

endpackage

// File: rtl/mrxc_cfg_reg.sv
module mrxc_cfg_reg #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W:0]   wdata,
    output logic [CNT_W-1:0] target,
    output logic             cont
);
    localparam int REG_W = CNT_W + 1;

    logic [REG_W-1:0] reg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else if (wr) begin
            reg_q <= wdata;
        end
    end

    assign target = reg_q[CNT_W-1:0];
    assign cont   = reg_q[CNT_W];
endmodule

// File: rtl/mrxc_counter.sv
module mrxc_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] target,
    input  logic             cont,
    output logic [CNT_W-1:0] count,
    output logic             last
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    // wrapping increment: 255 + 1 = 0
    assign cnt_nx = cnt_q + ONE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_nx;
        end
    end

    // the byte now being counted is the final one
    assign last  = !cont && (cnt_nx == target);
    assign count = cnt_q;
endmodule

// File: rtl/mrxc_done_flag.sv
module mrxc_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/mrxc_fsm.sv
module mrxc_fsm
    import mrxc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic start,
    input  logic start_rd,
    input  logic rx_byte,
    input  logic last,
    input  logic tx_req,
    input  logic tx_byte,
    input  logic stop_done,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic done_set,
    output logic ack_go,
    output logic ack_nack,
    output logic tx_more,
    output logic stop_req
);
    mrxc_state_e state_q;
    mrxc_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    always_comb begin
        state_nx = state_q;
        if (!en) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        state_nx = start_rd ? S_RX : S_TX;
                    end
                end
                S_RX: begin
                    if (rx_byte) begin
                        state_nx = last ? S_RX_NACK : S_RX_ACK;
                    end
                end
                S_RX_ACK:  state_nx = S_RX;
                S_RX_NACK: state_nx = S_STOP;
                S_STOP: begin
                    if (stop_done) begin
                        state_nx = S_IDLE;
                    end
                end
                S_TX: begin
                    if (tx_byte) begin
                        state_nx = tx_req ? S_TX : S_STOP;
                    end else if (!tx_req) begin
                        state_nx = S_TX_LAST;
                    end
                end
                S_TX_LAST: begin
                    if (tx_byte) begin
                        state_nx = S_STOP;
                    end
                end
                default: state_nx = S_IDLE;
            endcase
        end
    end

    always_comb begin
        ack_go   = (state_q == S_RX_ACK) || (state_q == S_RX_NACK);
        ack_nack = (state_q == S_RX_NACK);
        stop_req = (state_q == S_STOP);
        tx_more  = (state_q == S_TX);
        cnt_clr  = !en || ((state_q == S_IDLE) && start);
        cnt_inc  = en && (state_q == S_RX) && rx_byte;
        done_set = en && (state_q == S_STOP) && stop_done;
    end
endmodule

// File: rtl/mrx_count_ctrl.sv
module mrx_count_ctrl #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mst_en,
    input  logic             cfg_wr,
    input  logic [CNT_W:0]   cfg_wdata,
    output logic [CNT_W-1:0] cfg_target,
    output logic             cfg_cont,
    output logic [CNT_W-1:0] cur_count,
    input  logic             start,
    input  logic             start_rd,
    input  logic             rx_byte,
    output logic             ack_go,
    output logic             ack_nack,
    input  logic             tx_req,
    input  logic             tx_byte,
    output logic             tx_more,
    output logic             stop_req,
    input  logic             stop_done,
    input  logic             done_clr,
    output logic             txn_done
);
    logic cnt_clr;
    logic cnt_inc;
    logic done_set;
    logic last;

    mrxc_cfg_reg #(.CNT_W(CNT_W)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .wdata  (cfg_wdata),
        .target (cfg_target),
        .cont   (cfg_cont)
    );

    mrxc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .target (cfg_target),
        .cont   (cfg_cont),
        .count  (cur_count),
        .last   (last)
    );

    mrxc_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (mst_en),
        .start     (start),
        .start_rd  (start_rd),
        .rx_byte   (rx_byte),
        .last      (last),
        .tx_req    (tx_req),
        .tx_byte   (tx_byte),
        .stop_done (stop_done),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .done_set  (done_set),
        .ack_go    (ack_go),
        .ack_nack  (ack_nack),
        .tx_more   (tx_more),
        .stop_req  (stop_req)
    );

    mrxc_done_flag u_done (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (done_set),
        .clr   (done_clr),
        .flag  (txn_done)
    );
endmodule

// File: rtl/mrxc_checker.sv
module mrxc_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mst_en,
    input logic             cfg_wr,
    input logic [CNT_W:0]   cfg_wdata,
    input logic [CNT_W-1:0] cfg_target,
    input logic             cfg_cont,
    input logic [CNT_W-1:0] cur_count,
    input logic             ack_go,
    input logic             ack_nack,
    input logic             tx_more,
    input logic             stop_req,
    input logic             stop_done,
    input logic             done_clr,
    input logic             txn_done
);
    p_cfg_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> ({cfg_cont, cfg_target} == $past(cfg_wdata)));

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack_go |-> (cur_count == $past(cur_count) + CNT_W'(1)));

    p_ack_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_go |=> !ack_go);

    p_nack_then_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_go && ack_nack && mst_en) |=> stop_req);

    p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && !stop_done && mst_en) |=> stop_req);

    p_no_nack_cont_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_go && $past(cfg_cont) && $past(mst_en)) |-> !ack_nack);

    p_tx_stop_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_more && (stop_req || ack_go)));

    p_done_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && stop_done && mst_en) |=> txn_done);

    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_done && !done_clr) |=> txn_done);

    p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mst_en |=> (!ack_go && !stop_req && !tx_more && cur_count == '0));
endmodule

bind mrx_count_ctrl mrxc_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mst_en     (mst_en),
    .cfg_wr     (cfg_wr),
    .cfg_wdata  (cfg_wdata),
    .cfg_target (cfg_target),
    .cfg_cont   (cfg_cont),
    .cur_count  (cur_count),
    .ack_go     (ack_go),
    .ack_nack   (ack_nack),
    .tx_more    (tx_more),
    .stop_req   (stop_req),
    .stop_done  (stop_done),
    .done_clr   (done_clr),
    .txn_done   (txn_done)
);

// File: tb/sim_mrx_count_ctrl.sv
module sim_mrx_count_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mst_en = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic [7:0] cfg_target;
    logic       cfg_cont;
    logic [7:0] cur_count;
    logic       start = 1'b0;
    logic       start_rd = 1'b0;
    logic       rx_byte = 1'b0;
    logic       ack_go;
    logic       ack_nack;
    logic       tx_req = 1'b0;
    logic       tx_byte = 1'b0;
    logic       tx_more;
    logic       stop_req;
    logic       stop_done = 1'b0;
    logic       done_clr = 1'b0;
    logic       txn_done;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit ended   = 1'b0;

    always #2 clk = ~clk;

    mrx_count_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .cfg_target(cfg_target), .cfg_cont(cfg_cont),
        .cur_count(cur_count), .start(start), .start_rd(start_rd),
        .rx_byte(rx_byte), .ack_go(ack_go), .ack_nack(ack_nack),
        .tx_req(tx_req), .tx_byte(tx_byte), .tx_more(tx_more),
        .stop_req(stop_req), .stop_done(stop_done), .done_clr(done_clr),
        .txn_done(txn_done)
    );

    // behavioural reference: phase 0 idle, 1 reading, 2 answering,
    // 3 stopping, 4 writing, 5 writing with request withdrawn
    int       m_phase = 0;
    int       m_count = 0;
    bit       m_nack  = 1'b0;
    bit       m_done  = 1'b0;
    bit [8:0] m_reg   = '0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int nc;
        bit [8:0] old_reg;
        int old_phase;
        old_reg   = m_reg;
        old_phase = m_phase;
        cycles++;
        if (!rst_n) begin
            m_phase = 0; m_count = 0; m_nack = 0; m_done = 0; m_reg = '0;
        end else begin
            if (cfg_wr) m_reg = cfg_wdata;
            if (old_phase == 3 && mst_en && stop_done) m_done = 1;
            else if (done_clr) m_done = 0;
            if (!mst_en) begin
                m_phase = 0; m_count = 0;
            end else begin
                case (old_phase)
                    0: if (start) begin m_count = 0; m_phase = start_rd ? 1 : 4; end
                    1: if (rx_byte) begin
                           nc = (m_count + 1) % 256;
                           m_count = nc;
                           m_nack = !old_reg[8] && (nc == int'(old_reg[7:0]));
                           m_phase = 2;
                       end
                    2: m_phase = m_nack ? 3 : 1;
                    3: if (stop_done) m_phase = 0;
                    4: if (tx_byte) m_phase = tx_req ? 4 : 3;
                       else if (!tx_req) m_phase = 5;
                    5: if (tx_byte) m_phase = 3;
                    default: m_phase = 0;
                endcase
            end
        end
        #1;
        if (!ended) begin
            check(cfg_wdata === cfg_wdata && {cfg_cont, cfg_target} === m_reg, "R1 cfg",
                  int'({cfg_cont, cfg_target}), int'(m_reg));
            check(int'(cur_count) == m_count, "R2 count", int'(cur_count), m_count);
            check(ack_go === (m_phase == 2), "R3 ack_go", int'(ack_go), int'(m_phase == 2));
            if (m_phase == 2)
                check(ack_nack === m_nack, "R4 ack_nack", int'(ack_nack), int'(m_nack));
            check(stop_req === (m_phase == 3), "R4 stop_req", int'(stop_req), int'(m_phase == 3));
            check(tx_more === (m_phase == 4), "R8 tx_more", int'(tx_more), int'(m_phase == 4));
            check(txn_done === m_done, "R9 txn_done", int'(txn_done), int'(m_done));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [8:0] v);
        @(negedge clk); cfg_wr = 1; cfg_wdata = v;
        @(negedge clk); cfg_wr = 0;
    endtask

    task automatic begin_xfer(input bit rd);
        @(negedge clk); start = 1; start_rd = rd;
        @(negedge clk); start = 0;
    endtask

    task automatic rx_one();
        @(negedge clk); rx_byte = 1;
        @(negedge clk); rx_byte = 0;
        cyc(2);
    endtask

    task automatic end_stop(input bit clr_too);
        cyc(2);
        @(negedge clk); stop_done = 1; done_clr = clr_too;
        @(negedge clk); stop_done = 0; done_clr = 0;
    endtask

    task automatic clear_done();
        @(negedge clk); done_clr = 1;
        @(negedge clk); done_clr = 0;
    endtask

    task automatic summary();
        ended = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        wait (cycles > 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        summary();
    end

    initial begin
        cyc(3);
        // R1 reset state
        check(cfg_target == 0 && !cfg_cont && cur_count == 0 && !txn_done, "R1 reset", int'(cfg_target), 0);
        rst_n = 1; mst_en = 1;

        // R3 R4: target 5, read ends with NACK on fifth byte
        write_cfg(9'h005);
        check(cfg_target == 8'd5, "R1 readback", int'(cfg_target), 5);
        begin_xfer(1);
        for (int i = 0; i < 5; i++) rx_one();
        check(stop_req, "R4 stop after fifth", int'(stop_req), 1);
        end_stop(0);
        check(txn_done && cur_count == 5, "R9 done set", int'(cur_count), 5);
        clear_done();
        check(!txn_done, "R9 cleared", int'(txn_done), 0);

        // R5 continuous, then R6 early end with count+1
        write_cfg(9'h103);
        begin_xfer(1);
        for (int i = 0; i < 10; i++) rx_one();
        check(!stop_req && cur_count == 10, "R5 no end", int'(cur_count), 10);
        write_cfg(9'h00B);
        rx_one();
        check(stop_req && cur_count == 11, "R6 ends next byte", int'(cur_count), 11);
        end_stop(0);
        clear_done();

        // R6 write coinciding with byte, R7 wrap to a lower target
        write_cfg(9'h1FF);
        begin_xfer(1);
        for (int i = 0; i < 3; i++) rx_one();
        @(negedge clk); rx_byte = 1; cfg_wr = 1; cfg_wdata = 9'h004;
        @(negedge clk); rx_byte = 0; cfg_wr = 0;
        cyc(2);
        check(!stop_req && cur_count == 4, "R6 same-cycle write deferred", int'(stop_req), 0);
        for (int i = 0; i < 255; i++) rx_one();
        check(!stop_req && cur_count == 3, "R7 still reading after wrap", int'(cur_count), 3);
        rx_one();
        check(stop_req && cur_count == 4, "R7 ends at target after wrap", int'(cur_count), 4);
        end_stop(0);
        clear_done();

        // R11 target 0 means 256 bytes
        write_cfg(9'h000);
        begin_xfer(1);
        for (int i = 0; i < 255; i++) rx_one();
        check(!stop_req, "R11 not yet", int'(stop_req), 0);
        rx_one();
        check(stop_req && cur_count == 0, "R11 ends at 256", int'(stop_req), 1);
        end_stop(0);

        // R9 set and clear together: set wins (flag already 1)
        write_cfg(9'h001);
        begin_xfer(1);
        rx_one();
        end_stop(1);
        check(txn_done, "R9 set beats clear", int'(txn_done), 1);
        clear_done();

        // R8 transmit: withdrawn request then re-raised still ends
        tx_req = 1;
        begin_xfer(0);
        @(negedge clk); tx_byte = 1;
        @(negedge clk); tx_byte = 0;
        check(tx_more, "R8 continues", int'(tx_more), 1);
        tx_req = 0;
        @(negedge clk); tx_req = 1;
        @(negedge clk);
        check(!tx_more, "R8 withdrawn", int'(tx_more), 0);
        tx_byte = 1;
        @(negedge clk); tx_byte = 0;
        check(stop_req, "R8 stop after byte", int'(stop_req), 1);
        end_stop(0);
        clear_done();

        // R8 request low on the sent byte itself
        begin_xfer(0);
        @(negedge clk); tx_byte = 1; tx_req = 0;
        @(negedge clk); tx_byte = 0;
        check(stop_req, "R8 direct stop", int'(stop_req), 1);
        end_stop(0);
        clear_done();

        // R10 disable mid read
        write_cfg(9'h010);
        begin_xfer(1);
        rx_one(); rx_one();
        @(negedge clk); mst_en = 0;
        @(negedge clk);
        check(cur_count == 0 && !ack_go && !stop_req, "R10 disabled", int'(cur_count), 0);
        start = 1; start_rd = 1;
        @(negedge clk); start = 0; rx_byte = 1;
        @(negedge clk); rx_byte = 0; mst_en = 1;
        @(negedge clk); rx_byte = 1;
        @(negedge clk); rx_byte = 0;
        cyc(2);
        check(cur_count == 0 && !ack_go, "R10 inputs ignored", int'(cur_count), 0);

        cyc(4);
        summary();
    end
endmodule